// File: doc/BRIEF.md
# Host Mailbox and Inter-Processor Interrupt Registers

This block holds the two mailbox registers that carry messages between a core and an external host, together with the pair of registers the core uses to raise and acknowledge inter-processor interrupts. The core reaches all four through a single-cycle register port: a write strobe with an address and data, and a combinational read-data output for the address currently presented. The host has its own side port. From that port it can load the inbound mailbox, watch the outbound mailbox value, and clear the outbound mailbox once it has consumed the message.

The outbound (core-to-host) mailbox works as a one-deep slot. The core can post a message only while the slot is empty, which means it holds zero. A write that arrives while a message is still waiting is dropped, and the host frees the slot by clearing it. A nonzero value in the inbound (host-to-core) mailbox raises a host-interrupt line.

A write to the send register emits a one-cycle strobe that carries the written value as a target identifier toward the interrupt fabric. The strobe has no back-pressure: the fabric must accept it in the cycle it is valid. A write to the acknowledge register sets the local interrupt-pending flag to the least significant bit of the data, so software can either clear or raise its own pending flag.

Top module: `hostlink_mbox`

## Requirements
- R1: After reset both mailboxes hold zero, `host_irq`, `ipi_pending` and `ipi_send_valid` are low, and a read of either mailbox returns zero.
- R2: A core write (`csr_we`) to address 0 (outbound mailbox) while the mailbox holds zero stores `csr_wdata`. The value appears on `host_th_rdata` and on a core read of address 0 after the next clock edge.
- R3: A core write to address 0 while the outbound mailbox holds a nonzero value leaves the mailbox unchanged.
- R4: `host_th_clr` zeroes a nonzero outbound mailbox at the next edge. If the mailbox already holds zero in a cycle where the host clears it and the core writes it, the core write is stored.
- R5: A write to the inbound mailbox, either from the core at address 1 or from the host via `host_fh_we`, stores the value. `host_irq` is high from the next edge exactly when the stored value is nonzero. If both sides write in the same cycle, the host value is kept.
- R6: A core write to address 3 (interrupt acknowledge) sets `ipi_pending` to bit 0 of `csr_wdata` at the next edge.
- R7: A core write to address 2 (interrupt send) makes `ipi_send_valid` high for the one cycle after the write, with `ipi_send_target` equal to the written data. In any cycle that follows no such write, `ipi_send_valid` is low.
- R8: `csr_rdata` returns the stored value for addresses 0 and 1. It returns zero for addresses 2 and 3 and for every unmapped address (4 and above).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Core register write strobe |
| csr_addr | input | ADDR_W | Core register address |
| csr_wdata | input | DATA_W | Core write data |
| csr_rdata | output | DATA_W | Core read data for `csr_addr` (combinational) |
| host_fh_we | input | 1 | Host write strobe for the inbound mailbox |
| host_fh_wdata | input | DATA_W | Host write data for the inbound mailbox |
| host_th_clr | input | 1 | Host clear of the outbound mailbox |
| host_th_rdata | output | DATA_W | Current outbound mailbox value |
| host_irq | output | 1 | Inbound mailbox holds a nonzero value |
| ipi_pending | output | 1 | Local inter-processor interrupt pending flag |
| ipi_send_valid | output | 1 | One-cycle send strobe to the interrupt fabric |
| ipi_send_target | output | DATA_W | Target value carried with the send strobe |

## Verification
The bench builds the block with `DATA_W` = 16 and `ADDR_W` = 3, and keeps the default address map. With the narrow data path it is cheap to write values whose only set bit is the top bit or bit 0. Those values show whether the zero tests on both mailboxes look at the whole word. With three address bits, the unmapped addresses 4 to 7 can be reached, so the bench can check that reads there return zero.

// File: rtl/hostlink_pkg.sv
package hostlink_pkg;

  typedef enum logic [2:0] {
    SEL_NONE     = 3'd0,
    SEL_OUTBOX   = 3'd1,
    SEL_INBOX    = 3'd2,
    SEL_IPI_SEND = 3'd3,
    SEL_IPI_ACK  = 3'd4
  } reg_sel_e;

endpackage

// File: rtl/mbox_csr_decode.sv
module mbox_csr_decode
  import hostlink_pkg::*;
#(
  parameter int ADDR_W       = 3,
  parameter int OUTBOX_ADDR  = 0,
  parameter int INBOX_ADDR   = 1,
  parameter int SEND_ADDR    = 2,
  parameter int ACK_ADDR     = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);

  localparam logic [ADDR_W-1:0] A_OUT  = ADDR_W'(OUTBOX_ADDR);
  localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(INBOX_ADDR);
  localparam logic [ADDR_W-1:0] A_SEND = ADDR_W'(SEND_ADDR);
  localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(ACK_ADDR);

  always_comb begin
    if (addr == A_OUT)       sel = SEL_OUTBOX;
    else if (addr == A_IN)   sel = SEL_INBOX;
    else if (addr == A_SEND) sel = SEL_IPI_SEND;
    else if (addr == A_ACK)  sel = SEL_IPI_ACK;
    else                     sel = SEL_NONE;
  end

endmodule

// File: rtl/mbox_outbox_slot.sv
module mbox_outbox_slot #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_we,
  input  logic [DATA_W-1:0] core_wdata,
  input  logic              host_clr,
  output logic [DATA_W-1:0] value
);

  localparam logic [DATA_W-1:0] EMPTY = '0;

  logic slot_empty;
  logic accept;

  assign slot_empty = (value == EMPTY);
  // A post lands only into an empty slot; a full slot drops it.
  assign accept     = core_we && slot_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value <= EMPTY;
    end else if (accept) begin
      value <= core_wdata;
    end else if (host_clr) begin
      value <= EMPTY;
    end
  end

endmodule

// File: rtl/mbox_inbox_slot.sv
module mbox_inbox_slot #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_we,
  input  logic [DATA_W-1:0] core_wdata,
  input  logic              host_we,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] value,
  output logic              irq
);

  logic              any_we;
  logic [DATA_W-1:0] next_val;

  assign any_we   = core_we || host_we;
  // Host side wins a same-cycle collision.
  assign next_val = host_we ? host_wdata : core_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value <= '0;
      irq   <= 1'b0;
    end else if (any_we) begin
      value <= next_val;
      irq   <= |next_val;
    end
  end

endmodule

// File: rtl/mbox_ipi_ctrl.sv
module mbox_ipi_ctrl #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              send_we,
  input  logic              ack_we,
  input  logic [DATA_W-1:0] wdata,
  output logic              pending,
  output logic              send_valid,
  output logic [DATA_W-1:0] send_target
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
    end else if (ack_we) begin
      pending <= wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      send_valid  <= 1'b0;
      send_target <= '0;
    end else begin
      send_valid <= send_we;
      if (send_we) begin
        send_target <= wdata;
      end
    end
  end

endmodule

// File: rtl/hostlink_mbox.sv
module hostlink_mbox
  import hostlink_pkg::*;
#(
  parameter int DATA_W      = 64,
  parameter int ADDR_W      = 3,
  parameter int OUTBOX_ADDR = 0,
  parameter int INBOX_ADDR  = 1,
  parameter int SEND_ADDR   = 2,
  parameter int ACK_ADDR    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [DATA_W-1:0] csr_wdata,
  output logic [DATA_W-1:0] csr_rdata,
  input  logic              host_fh_we,
  input  logic [DATA_W-1:0] host_fh_wdata,
  input  logic              host_th_clr,
  output logic [DATA_W-1:0] host_th_rdata,
  output logic              host_irq,
  output logic              ipi_pending,
  output logic              ipi_send_valid,
  output logic [DATA_W-1:0] ipi_send_target
);

  reg_sel_e          sel;
  logic [DATA_W-1:0] outbox_q;
  logic [DATA_W-1:0] inbox_q;

  mbox_csr_decode #(
    .ADDR_W      (ADDR_W),
    .OUTBOX_ADDR (OUTBOX_ADDR),
    .INBOX_ADDR  (INBOX_ADDR),
    .SEND_ADDR   (SEND_ADDR),
    .ACK_ADDR    (ACK_ADDR)
  ) u_decode (
    .addr (csr_addr),
    .sel  (sel)
  );

  mbox_outbox_slot #(.DATA_W(DATA_W)) u_outbox (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_we    (csr_we && (sel == SEL_OUTBOX)),
    .core_wdata (csr_wdata),
    .host_clr   (host_th_clr),
    .value      (outbox_q)
  );

  mbox_inbox_slot #(.DATA_W(DATA_W)) u_inbox (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_we    (csr_we && (sel == SEL_INBOX)),
    .core_wdata (csr_wdata),
    .host_we    (host_fh_we),
    .host_wdata (host_fh_wdata),
    .value      (inbox_q),
    .irq        (host_irq)
  );

  mbox_ipi_ctrl #(.DATA_W(DATA_W)) u_ipi (
    .clk         (clk),
    .rst_n       (rst_n),
    .send_we     (csr_we && (sel == SEL_IPI_SEND)),
    .ack_we      (csr_we && (sel == SEL_IPI_ACK)),
    .wdata       (csr_wdata),
    .pending     (ipi_pending),
    .send_valid  (ipi_send_valid),
    .send_target (ipi_send_target)
  );

  // Send and acknowledge registers are write-only and read back as zero.
  always_comb begin
    unique case (sel)
      SEL_OUTBOX: csr_rdata = outbox_q;
      SEL_INBOX:  csr_rdata = inbox_q;
      default:    csr_rdata = '0;
    endcase
  end

  assign host_th_rdata = outbox_q;

endmodule

// File: rtl/hostlink_mbox_checker.sv
module hostlink_mbox_checker #(
  parameter int DATA_W      = 64,
  parameter int ADDR_W      = 3,
  parameter int OUTBOX_ADDR = 0,
  parameter int INBOX_ADDR  = 1,
  parameter int SEND_ADDR   = 2,
  parameter int ACK_ADDR    = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csr_we,
  input logic [ADDR_W-1:0] csr_addr,
  input logic [DATA_W-1:0] csr_wdata,
  input logic [DATA_W-1:0] csr_rdata,
  input logic              host_fh_we,
  input logic [DATA_W-1:0] host_fh_wdata,
  input logic              host_th_clr,
  input logic [DATA_W-1:0] host_th_rdata,
  input logic              host_irq,
  input logic              ipi_pending,
  input logic              ipi_send_valid,
  input logic [DATA_W-1:0] ipi_send_target
);

  localparam logic [ADDR_W-1:0] A_OUT  = ADDR_W'(OUTBOX_ADDR);
  localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(INBOX_ADDR);
  localparam logic [ADDR_W-1:0] A_SEND = ADDR_W'(SEND_ADDR);
  localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(ACK_ADDR);

  logic wr_out, wr_in, wr_send, wr_ack;
  assign wr_out  = csr_we && (csr_addr == A_OUT);
  assign wr_in   = csr_we && (csr_addr == A_IN);
  assign wr_send = csr_we && (csr_addr == A_SEND);
  assign wr_ack  = csr_we && (csr_addr == A_ACK);

  assert_full_outbox_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_out && (host_th_rdata != '0) && !host_th_clr) |=> $stable(host_th_rdata));

  assert_clear_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_th_clr && (host_th_rdata != '0)) |=> (host_th_rdata == '0));

  assert_post_into_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_out && (host_th_rdata == '0)) |=> (host_th_rdata == $past(csr_wdata)));

  assert_host_irq_host_R5: assert property (@(posedge clk) disable iff (!rst_n)
    host_fh_we |=> (host_irq == ($past(host_fh_wdata) != '0)));

  assert_host_irq_core_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_in && !host_fh_we) |=> (host_irq == ($past(csr_wdata) != '0)));

  assert_ack_sets_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |=> (ipi_pending == $past(csr_wdata[0])));

  assert_send_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_send |=> (ipi_send_valid && (ipi_send_target == $past(csr_wdata))));

  assert_no_spurious_send_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_send |=> !ipi_send_valid);

  assert_writeonly_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((csr_addr == A_SEND) || (csr_addr == A_ACK)) |-> (csr_rdata == '0));

endmodule

bind hostlink_mbox hostlink_mbox_checker #(
  .DATA_W      (DATA_W),
  .ADDR_W      (ADDR_W),
  .OUTBOX_ADDR (OUTBOX_ADDR),
  .INBOX_ADDR  (INBOX_ADDR),
  .SEND_ADDR   (SEND_ADDR),
  .ACK_ADDR    (ACK_ADDR)
) u_hostlink_mbox_checker (.*);

// File: tb/test_hostlink_mbox.sv
`timescale 1ns/1ps
module test_hostlink_mbox;

  localparam int DW = 16;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          csr_we = 1'b0;
  logic [AW-1:0] csr_addr = '0;
  logic [DW-1:0] csr_wdata = '0;
  logic [DW-1:0] csr_rdata;
  logic          host_fh_we = 1'b0;
  logic [DW-1:0] host_fh_wdata = '0;
  logic          host_th_clr = 1'b0;
  logic [DW-1:0] host_th_rdata;
  logic          host_irq;
  logic          ipi_pending;
  logic          ipi_send_valid;
  logic [DW-1:0] ipi_send_target;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hostlink_mbox #(.DATA_W(DW), .ADDR_W(AW)) i_hostlink_mbox (
    .clk, .rst_n, .csr_we, .csr_addr, .csr_wdata, .csr_rdata,
    .host_fh_we, .host_fh_wdata, .host_th_clr, .host_th_rdata,
    .host_irq, .ipi_pending, .ipi_send_valid, .ipi_send_target
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock with all inputs driven; results sampled just after the edge.
  task automatic cycle(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic clr, input logic fwe, input logic [DW-1:0] fd);
    @(negedge clk);
    csr_we = we; csr_addr = a; csr_wdata = d;
    host_th_clr = clr; host_fh_we = fwe; host_fh_wdata = fd;
    @(posedge clk);
    #1;
    csr_we = 1'b0; host_th_clr = 1'b0; host_fh_we = 1'b0;
  endtask

  task automatic read_at(input logic [AW-1:0] a, output logic [DW-1:0] v);
    @(negedge clk);
    csr_addr = a;
    #1 v = csr_rdata;
  endtask

  task automatic t_reset;
    logic [DW-1:0] v;
    check("R1 outbox", host_th_rdata, '0);
    check("R1 host_irq", DW'(host_irq), '0);
    check("R1 ipi_pending", DW'(ipi_pending), '0);
    check("R1 send_valid", DW'(ipi_send_valid), '0);
    read_at(3'd1, v); check("R1 inbox read", v, '0);
    read_at(3'd0, v); check("R1 outbox read", v, '0);
  endtask

  task automatic t_outbox;
    logic [DW-1:0] v;
    cycle(1, 3'd0, 16'h8000, 0, 0, '0);
    check("R2 outbox post", host_th_rdata, 16'h8000);
    read_at(3'd0, v); check("R2 outbox core read", v, 16'h8000);
    cycle(1, 3'd0, 16'h5555, 0, 0, '0);
    check("R3 full outbox ignores write", host_th_rdata, 16'h8000);
    cycle(0, 3'd0, '0, 1, 0, '0);
    check("R4 host clear", host_th_rdata, '0);
    cycle(1, 3'd0, 16'h0001, 0, 0, '0);
    check("R2 post after clear", host_th_rdata, 16'h0001);
    cycle(1, 3'd0, 16'h7777, 1, 0, '0);
    check("R4 clear beats write to full", host_th_rdata, '0);
    cycle(1, 3'd0, 16'h2468, 1, 0, '0);
    check("R4 write lands into empty despite clear", host_th_rdata, 16'h2468);
    cycle(0, 3'd0, '0, 1, 0, '0);
  endtask

  task automatic t_inbox;
    logic [DW-1:0] v;
    cycle(1, 3'd1, 16'h8000, 0, 0, '0);
    check("R5 irq after core write", DW'(host_irq), 16'd1);
    read_at(3'd1, v); check("R5 inbox read", v, 16'h8000);
    cycle(1, 3'd1, 16'h0000, 0, 0, '0);
    check("R5 irq drops on zero", DW'(host_irq), '0);
    cycle(0, 3'd0, '0, 0, 1, 16'h0001);
    check("R5 irq after host write", DW'(host_irq), 16'd1);
    cycle(1, 3'd1, 16'h0000, 0, 1, 16'h0007);
    check("R5 host wins collision irq", DW'(host_irq), 16'd1);
    read_at(3'd1, v); check("R5 host wins collision value", v, 16'h0007);
    cycle(1, 3'd1, 16'h00f0, 0, 1, 16'h0000);
    check("R5 host zero wins collision", DW'(host_irq), '0);
    cycle(0, 3'd0, '0, 0, 1, 16'h1234);
  endtask

  task automatic t_ipi;
    logic [DW-1:0] v;
    cycle(1, 3'd3, 16'h0003, 0, 0, '0);
    check("R6 ack bit0 set", DW'(ipi_pending), 16'd1);
    cycle(1, 3'd3, 16'h0002, 0, 0, '0);
    check("R6 ack bit0 clear", DW'(ipi_pending), '0);
    cycle(1, 3'd2, 16'hbeef, 0, 0, '0);
    check("R7 send valid", DW'(ipi_send_valid), 16'd1);
    check("R7 send target", ipi_send_target, 16'hbeef);
    check("R7 send no effect on pending", DW'(ipi_pending), '0);
    @(posedge clk); #1;
    check("R7 strobe one cycle", DW'(ipi_send_valid), '0);
    cycle(1, 3'd2, 16'h0011, 0, 0, '0);
    check("R7 b2b first", ipi_send_target, 16'h0011);
    cycle(1, 3'd2, 16'h0022, 0, 0, '0);
    check("R7 b2b second valid", DW'(ipi_send_valid), 16'd1);
    check("R7 b2b second target", ipi_send_target, 16'h0022);
    read_at(3'd2, v); check("R8 send reads zero", v, '0);
    read_at(3'd3, v); check("R8 ack reads zero", v, '0);
    read_at(3'd5, v); check("R8 unmapped reads zero", v, '0);
    read_at(3'd1, v); check("R8 inbox still readable", v, 16'h1234);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_outbox();
    t_inbox();
    t_ipi();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule